// File: doc/BRIEF.md
# Hit-Under-Miss Register Scoreboard

This block lets an in-order pipeline continue past a single data-cache miss. When a miss is reported from the MEM stage and no other miss is in flight, the block takes ownership of it. If the miss belongs to a load, the load's destination register is marked as unavailable. Younger instructions in EX keep flowing, unless they read that register or write it. Those instructions are held in EX until the fill returns.

A second load or store miss that arrives while the first is still outstanding cannot be tracked. The block holds that miss at the EX/MEM boundary. When main memory answers on the return handshake, the block writes the fill value back to the register file port in that same cycle. The busy mark and any dependent EX hold are lifted on the next clock. Register zero is hard-wired, so a load that targets it never marks anything busy and produces no write-back.

Top module: `hum_scoreboard`

## Requirements
- R1: After reset, miss_pending, busy, ex_stall, mem_stall and fill_we are all 0.
- R2: A miss (mem_miss_valid=1) while miss_pending=0 gives miss_accept=1 and mem_stall=0 in the same cycle. From the next cycle miss_pending=1. For a load (mem_miss_is_load=1) with a non-zero destination, busy=1 and busy_reg equals the load's destination.
- R3: While busy=1 and ex_valid=1, ex_stall is 1 in the same cycle if rs1 is used and equals busy_reg, or if rs2 is used and equals busy_reg.
- R4: While busy=1, an EX instruction that does not touch busy_reg gives ex_stall=0. This covers a source index that matches but has its use flag at 0.
- R5: While busy=1 and ex_valid=1, an EX instruction that writes (ex_rd_wr=1) register busy_reg gives ex_stall=1.
- R6: A load or store miss while miss_pending=1 gives mem_stall=1 and miss_accept=0 in the same cycle, and busy_reg is unchanged afterwards.
- R7: When ret_valid=1 while the pending miss is a load with non-zero destination, fill_we=1, fill_rd=busy_reg and fill_data=ret_data in that cycle. ex_stall may still be 1 in that cycle. On the next cycle busy=0, miss_pending=0 and ex_stall=0.
- R8: A load miss with destination 0 is accepted and sets miss_pending. It never sets busy, never stalls EX, and its return gives fill_we=0.
- R9: A store miss (mem_miss_is_load=0) with nothing pending is accepted and sets miss_pending but not busy. Its return gives fill_we=0 and clears miss_pending on the next cycle.
- R10: ret_valid while miss_pending=0 is ignored. fill_we stays 0 and the state is unchanged.
- R11: ex_valid=0 gives ex_stall=0 whatever the operand fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | An instruction occupies EX |
| ex_rs1_use | input | 1 | EX instruction reads source 1 |
| ex_rs1 | input | REG_W | Source 1 register index |
| ex_rs2_use | input | 1 | EX instruction reads source 2 |
| ex_rs2 | input | REG_W | Source 2 register index |
| ex_rd_wr | input | 1 | EX instruction writes a register |
| ex_rd | input | REG_W | EX destination register index |
| mem_miss_valid | input | 1 | A load or store missed the cache in MEM |
| mem_miss_is_load | input | 1 | 1 for load miss, 0 for store miss |
| mem_miss_rd | input | REG_W | Destination of the missing load |
| ret_valid | input | 1 | Memory has returned the fill |
| ret_data | input | DATA_W | Returned fill value |
| miss_accept | output | 1 | The current miss is taken without stall |
| mem_stall | output | 1 | Hold EX/MEM: second miss while one is pending |
| ex_stall | output | 1 | Hold EX: instruction conflicts with busy register |
| miss_pending | output | 1 | One miss is outstanding |
| busy | output | 1 | A register awaits fill data |
| busy_reg | output | REG_W | Index of the register awaiting fill |
| fill_we | output | 1 | Register-file write enable for the fill |
| fill_rd | output | REG_W | Register written by the fill |
| fill_data | output | DATA_W | Value written by the fill |

## Verification
A corrupted pending flag shows up at once as a wrong split between miss_accept and mem_stall on the next miss. It also shows up as a return that is taken or ignored wrongly. A wrong stored destination shows up in the same cycle as an EX hold on the wrong register, and as a fill aimed at the wrong index. Stale busy state shows up one cycle after a return as an EX hold that persists. The bench probes every hazard kind both on the busy index and next to it, in the cycles right before and right after the return.

// File: rtl/hum_pkg.sv
package hum_pkg;
    // Operand slots compared against the busy register
    typedef enum int unsigned {
        SLOT_RS1 = 0,
        SLOT_RS2 = 1,
        SLOT_RD  = 2
    } slot_e;

    localparam int unsigned NUM_SLOTS = 3;
endpackage

// File: rtl/hum_miss_tracker.sv
module hum_miss_tracker #(
    parameter int unsigned REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_miss_valid,
    input  logic             mem_miss_is_load,
    input  logic [REG_W-1:0] mem_miss_rd,
    input  logic             ret_valid,
    output logic             miss_accept,
    output logic             mem_stall,
    output logic             ret_take,
    output logic             pending,
    output logic             wb_valid,
    output logic [REG_W-1:0] wb_rd
);
    typedef struct packed {
        logic             pending;
        logic             wb_valid;
        logic [REG_W-1:0] rd;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        miss_accept = mem_miss_valid && !st_q.pending;
        mem_stall   = mem_miss_valid && st_q.pending;
        ret_take    = ret_valid && st_q.pending;
        if (st_q.pending) begin
            if (ret_valid) begin
                st_d = '0;
            end
        end else if (mem_miss_valid) begin
            st_d.pending  = 1'b1;
            st_d.wb_valid = mem_miss_is_load && (mem_miss_rd != '0);
            st_d.rd       = mem_miss_is_load ? mem_miss_rd : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending  = st_q.pending;
    assign wb_valid = st_q.wb_valid;
    assign wb_rd    = st_q.rd;

    // R2: a fresh pending state only follows an accepted miss
    a_r2_pending_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(miss_accept));

    // R2: accepted load with non-zero destination records that register
    a_r2_load_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_accept && mem_miss_is_load && mem_miss_rd != '0)
            |=> (wb_valid && wb_rd == $past(mem_miss_rd)));

    // R6: while pending and no return, the tracked register is held
    a_r6_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ret_valid) |=> (pending && $stable(wb_rd) && $stable(wb_valid)));

    // R7: a return clears the pending miss on the next cycle
    a_r7_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> (!pending && !wb_valid));

    // R8: register zero is never marked busy
    a_r8_zero_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_rd != '0));
endmodule

// File: rtl/hum_hazard_cmp.sv
module hum_hazard_cmp
    import hum_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ex_valid,
    input  logic                            tag_valid,
    input  logic [REG_W-1:0]                tag,
    input  logic [NUM_SLOTS-1:0]            slot_use,
    input  logic [NUM_SLOTS-1:0][REG_W-1:0] slot_idx,
    output logic                            hit
);
    logic [NUM_SLOTS-1:0] match;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign match[g] = slot_use[g] && (slot_idx[g] == tag);
    end

    assign hit = ex_valid && tag_valid && (|match);

    // R11: no hold without an instruction in EX
    a_r11_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> !hit);

    // R4: an instruction touching nothing busy is never held
    a_r4_unrelated_free: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid && ex_valid && !slot_use[SLOT_RS1] && !slot_use[SLOT_RS2]
            && !slot_use[SLOT_RD]) |-> !hit);
endmodule

// File: rtl/hum_fill_path.sv
module hum_fill_path #(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              ret_take,
    input  logic              wb_valid,
    input  logic [REG_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] ret_data,
    output logic              fill_we,
    output logic [REG_W-1:0]  fill_rd,
    output logic [DATA_W-1:0] fill_data
);
    always_comb begin
        fill_we   = ret_take && wb_valid;
        fill_rd   = wb_rd;
        fill_data = ret_data;
    end
endmodule

// File: rtl/hum_scoreboard.sv
module hum_scoreboard
    import hum_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic              ex_rs1_use,
    input  logic [REG_W-1:0]  ex_rs1,
    input  logic              ex_rs2_use,
    input  logic [REG_W-1:0]  ex_rs2,
    input  logic              ex_rd_wr,
    input  logic [REG_W-1:0]  ex_rd,
    input  logic              mem_miss_valid,
    input  logic              mem_miss_is_load,
    input  logic [REG_W-1:0]  mem_miss_rd,
    input  logic              ret_valid,
    input  logic [DATA_W-1:0] ret_data,
    output logic              miss_accept,
    output logic              mem_stall,
    output logic              ex_stall,
    output logic              miss_pending,
    output logic              busy,
    output logic [REG_W-1:0]  busy_reg,
    output logic              fill_we,
    output logic [REG_W-1:0]  fill_rd,
    output logic [DATA_W-1:0] fill_data
);
    logic                            ret_take;
    logic                            wb_valid;
    logic [REG_W-1:0]                wb_rd;
    logic [NUM_SLOTS-1:0]            slot_use;
    logic [NUM_SLOTS-1:0][REG_W-1:0] slot_idx;

    hum_miss_tracker #(.REG_W(REG_W)) u_tracker (
        .clk              (clk),
        .rst_n            (rst_n),
        .mem_miss_valid   (mem_miss_valid),
        .mem_miss_is_load (mem_miss_is_load),
        .mem_miss_rd      (mem_miss_rd),
        .ret_valid        (ret_valid),
        .miss_accept      (miss_accept),
        .mem_stall        (mem_stall),
        .ret_take         (ret_take),
        .pending          (miss_pending),
        .wb_valid         (wb_valid),
        .wb_rd            (wb_rd)
    );

    always_comb begin
        slot_use[SLOT_RS1] = ex_rs1_use;
        slot_idx[SLOT_RS1] = ex_rs1;
        slot_use[SLOT_RS2] = ex_rs2_use;
        slot_idx[SLOT_RS2] = ex_rs2;
        slot_use[SLOT_RD]  = ex_rd_wr;
        slot_idx[SLOT_RD]  = ex_rd;
    end

    hum_hazard_cmp #(.REG_W(REG_W)) u_hazard (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_valid  (ex_valid),
        .tag_valid (wb_valid),
        .tag       (wb_rd),
        .slot_use  (slot_use),
        .slot_idx  (slot_idx),
        .hit       (ex_stall)
    );

    hum_fill_path #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fill (
        .ret_take  (ret_take),
        .wb_valid  (wb_valid),
        .wb_rd     (wb_rd),
        .ret_data  (ret_data),
        .fill_we   (fill_we),
        .fill_rd   (fill_rd),
        .fill_data (fill_data)
    );

    assign busy     = wb_valid;
    assign busy_reg = wb_rd;

    // R3: an EX hold implies a register is actually busy
    a_r3_stall_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ex_stall |-> busy);

    // R7: fill targets the busy register
    a_r7_fill_target: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (busy && fill_rd == busy_reg && ret_valid));

    // R6: accept and MEM hold never coincide
    a_r6_accept_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_accept && mem_stall));

    // R10: a return with nothing pending writes nothing
    a_r10_stray_return: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !miss_pending) |-> !fill_we);
endmodule

// File: tb/hum_scoreboard_bench.sv
module hum_scoreboard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ex_valid, ex_rs1_use, ex_rs2_use, ex_rd_wr;
    logic [REG_W-1:0]  ex_rs1, ex_rs2, ex_rd;
    logic              mem_miss_valid, mem_miss_is_load;
    logic [REG_W-1:0]  mem_miss_rd;
    logic              ret_valid;
    logic [DATA_W-1:0] ret_data;
    logic              miss_accept, mem_stall, ex_stall, miss_pending, busy, fill_we;
    logic [REG_W-1:0]  busy_reg, fill_rd;
    logic [DATA_W-1:0] fill_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hum_scoreboard u_hum_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_rs1_use(ex_rs1_use), .ex_rs1(ex_rs1),
        .ex_rs2_use(ex_rs2_use), .ex_rs2(ex_rs2), .ex_rd_wr(ex_rd_wr), .ex_rd(ex_rd),
        .mem_miss_valid(mem_miss_valid), .mem_miss_is_load(mem_miss_is_load),
        .mem_miss_rd(mem_miss_rd), .ret_valid(ret_valid), .ret_data(ret_data),
        .miss_accept(miss_accept), .mem_stall(mem_stall), .ex_stall(ex_stall),
        .miss_pending(miss_pending), .busy(busy), .busy_reg(busy_reg),
        .fill_we(fill_we), .fill_rd(fill_rd), .fill_data(fill_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ex_valid = 0; ex_rs1_use = 0; ex_rs2_use = 0; ex_rd_wr = 0;
        ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_miss_valid = 0; mem_miss_is_load = 0; mem_miss_rd = 0;
        ret_valid = 0; ret_data = 0;
    endtask

    // advance one clock, land 1 time unit after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic ex_instr(input logic u1, input logic [REG_W-1:0] r1,
                            input logic u2, input logic [REG_W-1:0] r2,
                            input logic w,  input logic [REG_W-1:0] rd);
        ex_valid = 1; ex_rs1_use = u1; ex_rs1 = r1;
        ex_rs2_use = u2; ex_rs2 = r2; ex_rd_wr = w; ex_rd = rd;
    endtask

    task automatic issue_miss(input logic is_load, input logic [REG_W-1:0] rd);
        mem_miss_valid = 1; mem_miss_is_load = is_load; mem_miss_rd = rd;
        settle();
        chk("R2 accept", miss_accept, 1);
        chk("R2 no mem stall", mem_stall, 0);
        step();
        mem_miss_valid = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        settle();
        chk("R1 pending", miss_pending, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ex_stall", ex_stall, 0);
        chk("R1 mem_stall", mem_stall, 0);
        chk("R1 fill_we", fill_we, 0);
    endtask

    task automatic t_load_hazards();
        issue_miss(1'b1, 5'd7);
        chk("R2 pending", miss_pending, 1);
        chk("R2 busy", busy, 1);
        chk("R2 busy_reg", busy_reg, 7);
        ex_instr(1, 7, 0, 0, 0, 0); settle();
        chk("R3 rs1 hit", ex_stall, 1);
        ex_instr(0, 0, 1, 7, 0, 0); settle();
        chk("R3 rs2 hit", ex_stall, 1);
        ex_instr(1, 6, 1, 8, 1, 9); settle();
        chk("R4 neighbours", ex_stall, 0);
        ex_instr(0, 7, 0, 7, 0, 7); settle();
        chk("R4 unused fields", ex_stall, 0);
        ex_instr(0, 0, 0, 0, 1, 7); settle();
        chk("R5 write busy", ex_stall, 1);
        ex_valid = 0; settle();
        chk("R11 ex invalid", ex_stall, 0);
        // unrelated work keeps completing across cycles
        ex_instr(1, 3, 1, 4, 1, 5); step();
        chk("R4 still busy", busy, 1);
        chk("R4 flows", ex_stall, 0);
        // return while dependent instruction sits in EX
        ex_instr(1, 7, 0, 0, 0, 0);
        ret_valid = 1; ret_data = 32'hCAFE_0107; settle();
        chk("R7 fill_we", fill_we, 1);
        chk("R7 fill_rd", fill_rd, 7);
        chk("R7 fill_data", fill_data, 32'hCAFE_0107);
        chk("R7 stall in return cycle", ex_stall, 1);
        step();
        ret_valid = 0; settle();
        chk("R7 busy cleared", busy, 0);
        chk("R7 pending cleared", miss_pending, 0);
        chk("R7 stall released", ex_stall, 0);
        chk("R7 no repeat fill", fill_we, 0);
        idle_inputs();
    endtask

    task automatic t_second_miss();
        issue_miss(1'b1, 5'd12);
        mem_miss_valid = 1; mem_miss_is_load = 1; mem_miss_rd = 5'd13; settle();
        chk("R6 load mem_stall", mem_stall, 1);
        chk("R6 load no accept", miss_accept, 0);
        step();
        chk("R6 busy_reg kept", busy_reg, 12);
        mem_miss_is_load = 0; settle();
        chk("R6 store mem_stall", mem_stall, 1);
        chk("R6 store no accept", miss_accept, 0);
        step();
        chk("R6 busy_reg kept 2", busy_reg, 12);
        // miss held through the return cycle, then accepted next
        mem_miss_is_load = 1; mem_miss_rd = 5'd13;
        ret_valid = 1; ret_data = 32'h12; settle();
        chk("R6 stall on return cycle", mem_stall, 1);
        chk("R7 fill rd 12", fill_rd, 12);
        step();
        ret_valid = 0; settle();
        chk("R2 accept after return", miss_accept, 1);
        step();
        mem_miss_valid = 0; settle();
        chk("R2 new busy_reg", busy_reg, 13);
        ret_valid = 1; step(); ret_valid = 0; settle();
        chk("R7 cleared again", miss_pending, 0);
        idle_inputs();
    endtask

    task automatic t_zero_dest();
        issue_miss(1'b1, 5'd0);
        chk("R8 pending", miss_pending, 1);
        chk("R8 not busy", busy, 0);
        ex_instr(1, 0, 1, 0, 1, 0); settle();
        chk("R8 no ex stall", ex_stall, 0);
        ret_valid = 1; ret_data = 32'h55; settle();
        chk("R8 no fill", fill_we, 0);
        step(); ret_valid = 0; settle();
        chk("R8 pending cleared", miss_pending, 0);
        idle_inputs();
    endtask

    task automatic t_store_miss();
        issue_miss(1'b0, 5'd9);
        chk("R9 pending", miss_pending, 1);
        chk("R9 not busy", busy, 0);
        ex_instr(1, 9, 1, 9, 1, 9); settle();
        chk("R9 no ex stall", ex_stall, 0);
        ret_valid = 1; settle();
        chk("R9 no fill", fill_we, 0);
        step(); ret_valid = 0; settle();
        chk("R9 pending cleared", miss_pending, 0);
        idle_inputs();
    endtask

    task automatic t_stray_return();
        ret_valid = 1; ret_data = 32'hDEAD; settle();
        chk("R10 no fill", fill_we, 0);
        step(); ret_valid = 0;
        step();
        chk("R10 still idle", miss_pending, 0);
        chk("R10 not busy", busy, 0);
        issue_miss(1'b1, 5'd4);
        ret_valid = 1; settle();
        chk("R10 real return fills", fill_rd, 4);
        step(); ret_valid = 0; settle();
        chk("R10 clean after", busy, 0);
        idle_inputs();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load_hazards();
        t_second_miss();
        t_zero_dest();
        t_store_miss();
        t_stray_return();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule